// File: doc/BRIEF.md
# Iterative Scalable Feistel Block Cipher

This block is a loop-architecture cipher core for a lightweight, parameter-scaled Feistel cipher. The block and key widths (`N`), the word width (`B`) and an odd round count (`NR`) are parameters. A start strobe loads an `N`-bit data block, an `N`-bit key and a direction select. The core then performs one full round per clock. In the same cycle it advances the data round and the on-the-fly key schedule. When the last round completes it presents the result and pulses `done_o`.

Each half of the block, called a branch, is `N/2` bits wide and holds `NB = N/(2B)` words of `B` bits. The data round uses five steps: word-wise modular addition, a 3-bit substitution applied bit-sliced across word triples, a per-triple bit rotation, a word rotation and an XOR. Encryption and decryption share the same key schedule. That schedule swaps its two halves once, at the midpoint of the run, so that the round keys come out in mirror order. A legal configuration needs `N` to be a multiple of `6*B` and `NR` to be odd. The constant for each round must also fit in `B` bits.

Top module: `sfc_core`

## Requirements
- R1: `done_o` is high exactly `NR` clock edges after the edge that accepted `start_i`.
- R2: `done_o` is high for a single cycle per accepted start.
- R3: With `encrypt_i=1`, the result equals the reference cipher. The following layout and operations define it.
  - Block bits `[N-1:N/2]` form the left branch. Key bits `[N-1:N/2]` form the left key half.
  - Word `w` of a branch is bits `[w*B +: B]`.
  - The substitution maps 0..7 to 0,5,6,7,4,3,1,2. Its input is `{word 3t+2 bit j, word 3t+1 bit j, word 3t bit j}`, and output bit 0/1/2 goes back to word 3t/3t+1/3t+2.
  - The bit rotation turns word 3t right by one, leaves word 3t+1 as it is, and turns word 3t+2 left by one.
  - The word rotation moves word `w` to `w+1`, and the top word wraps to 0.
  - F(x,k) is the bit rotation of the substitution of `x+k`, where the addition is word-wise. An encrypt round maps (L,R) to (R, wrot(L) xor F(R,k)).
  - The round key is the right key half for rounds 1..NR/2 and the left key half after that. The key step maps (KL,KR) to (KR, KL xor wrot(F(KR,c))). The constant `c` is the round index while the round index is at most NR/2, and NR minus the round index otherwise. After round NR/2, the two key halves are exchanged.
  - The result is `{R, L}` after round NR, with R in the upper half.
- R4: Decrypting an encryption result under the same key returns the original block.
- R5: A `start_i` pulse that arrives while a run is in progress is ignored. It does not change the running result, and it produces no extra `done_o`.
- R6: `result_o` changes only on the edge that raises `done_o`. Otherwise it holds.
- R7: After reset, `done_o` is 0 and `result_o` is 0.
- R8: With `encrypt_i=0`, the decrypt round maps (L,R) to (R, wrot_inv(L xor F(R,k))). Here wrot_inv moves word `w+1` to `w`. The key schedule and the output layout are the same as in R3.
- R9: The per-word additions pass no carry between words, including when every word overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run when the core is idle |
| encrypt_i | input | 1 | 1 selects encryption, 0 selects decryption, captured at start |
| block_i | input | N | Data block, captured at start |
| key_i | input | N | Key, captured at start |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | N | Result of the last completed run |

## Verification
The only result of a run is due exactly `NR` edges after the accepting edge. That is when the result register and the `done_o` register are both written. The driver records the edge number at which each start will be sampled and queues the due edge together with the expected block. The monitor samples at falling edges. On every `done_o` it pops one item and compares both the block and the edge count. It also flags any change of `result_o` while `done_o` is low, any two-cycle `done_o`, and any `done_o` with nothing queued, which is how a start accepted while busy would show up.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  // 3-bit substitution applied bit-sliced over word triples
  function automatic logic [2:0] sbox3(input logic [2:0] v);
    logic [2:0] s;
    case (v)
      3'd0:    s = 3'd0;
      3'd1:    s = 3'd5;
      3'd2:    s = 3'd6;
      3'd3:    s = 3'd7;
      3'd4:    s = 3'd4;
      3'd5:    s = 3'd3;
      3'd6:    s = 3'd1;
      default: s = 3'd2;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sfc_sbox_layer.sv
module sfc_sbox_layer #(
  parameter int unsigned NB = 6,
  parameter int unsigned B  = 8
) (
  input  logic [NB*B-1:0] x_i,
  output logic [NB*B-1:0] y_o
);
  localparam int unsigned NT = NB / 3;

  for (genvar t = 0; t < NT; t++) begin : g_tri
    for (genvar j = 0; j < B; j++) begin : g_bit
      logic [2:0] v;
      logic [2:0] s;
      assign v = {x_i[(3*t+2)*B + j], x_i[(3*t+1)*B + j], x_i[(3*t)*B + j]};
      assign s = sfc_pkg::sbox3(v);
      assign y_o[(3*t)*B + j]   = s[0];
      assign y_o[(3*t+1)*B + j] = s[1];
      assign y_o[(3*t+2)*B + j] = s[2];
    end
  end

endmodule

// File: rtl/sfc_round_fn.sv
// y = bitrot(sbox(x + k)), addition independent per word
module sfc_round_fn #(
  parameter int unsigned NB = 6,
  parameter int unsigned B  = 8
) (
  input  logic [NB*B-1:0] x_i,
  input  logic [NB*B-1:0] k_i,
  output logic [NB*B-1:0] y_o
);
  localparam int unsigned W  = NB * B;
  localparam int unsigned NT = NB / 3;

  logic [W-1:0] sum;
  logic [W-1:0] sub;

  for (genvar w = 0; w < NB; w++) begin : g_add
    assign sum[w*B +: B] = x_i[w*B +: B] + k_i[w*B +: B];
  end

  sfc_sbox_layer #(.NB(NB), .B(B)) u_sbox (
    .x_i (sum),
    .y_o (sub)
  );

  for (genvar t = 0; t < NT; t++) begin : g_brot
    logic [B-1:0] w0, w1, w2;
    assign w0 = sub[(3*t)*B   +: B];
    assign w1 = sub[(3*t+1)*B +: B];
    assign w2 = sub[(3*t+2)*B +: B];
    assign y_o[(3*t)*B   +: B] = {w0[0], w0[B-1:1]};
    assign y_o[(3*t+1)*B +: B] = w1;
    assign y_o[(3*t+2)*B +: B] = {w2[B-2:0], w2[B-1]};
  end

endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl #(
  parameter int unsigned NR = 93,
  localparam int unsigned RW = $clog2(NR + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          load_o,
  output logic          busy_o,
  output logic          last_o,
  output logic          lo_half_o,
  output logic          swap_o,
  output logic          done_o,
  output logic [RW-1:0] rnd_o,
  output logic [RW-1:0] rconst_o
);
  import sfc_pkg::*;

  localparam int unsigned HALF = NR / 2;

  phase_e        ph_q, ph_d;
  logic [RW-1:0] rnd_q, rnd_d;
  logic          done_q, done_d;

  assign busy_o    = (ph_q == PH_RUN);
  assign load_o    = start_i && !busy_o;
  assign last_o    = (rnd_q == RW'(NR));
  assign lo_half_o = (rnd_q <= RW'(HALF));
  assign swap_o    = (rnd_q == RW'(HALF));
  assign rconst_o  = lo_half_o ? rnd_q : (RW'(NR) - rnd_q);
  assign rnd_o     = rnd_q;
  assign done_o    = done_q;

  always_comb begin
    ph_d   = ph_q;
    rnd_d  = rnd_q;
    done_d = 1'b0;
    if (load_o) begin
      ph_d  = PH_RUN;
      rnd_d = RW'(1);
    end else if (busy_o) begin
      if (last_o) begin
        ph_d   = PH_IDLE;
        rnd_d  = '0;
        done_d = 1'b1;
      end else begin
        rnd_d = rnd_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      rnd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      rnd_q  <= rnd_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/sfc_core.sv
module sfc_core #(
  parameter int unsigned N  = 96,
  parameter int unsigned B  = 8,
  parameter int unsigned NR = 93
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         encrypt_i,
  input  logic [N-1:0] block_i,
  input  logic [N-1:0] key_i,
  output logic         done_o,
  output logic [N-1:0] result_o
);
  localparam int unsigned H  = N / 2;
  localparam int unsigned NB = H / B;
  localparam int unsigned RW = $clog2(NR + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  logic          load, busy, last, lo_half, swap;
  logic [RW-1:0] rnd, rconst;

  sfc_ctrl #(.NR(NR)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .start_i   (start_i),
    .load_o    (load),
    .busy_o    (busy),
    .last_o    (last),
    .lo_half_o (lo_half),
    .swap_o    (swap),
    .done_o    (done_o),
    .rnd_o     (rnd),
    .rconst_o  (rconst)
  );

  logic [H-1:0] l_q, r_q, kl_q, kr_q;
  logic [H-1:0] l_d, r_d, kl_d, kr_d;
  logic         enc_q, enc_d;
  logic [N-1:0] res_q, res_d;
  logic         st_en, res_en;

  // data round
  logic [H-1:0] rkey, f_dat, l_wrot, mix, mix_wrot_inv, r_new;
  assign rkey = lo_half ? kr_q : kl_q;

  sfc_round_fn #(.NB(NB), .B(B)) u_data (
    .x_i (r_q),
    .k_i (rkey),
    .y_o (f_dat)
  );

  assign l_wrot       = {l_q[H-B-1:0], l_q[H-1:H-B]};
  assign mix          = l_q ^ f_dat;
  assign mix_wrot_inv = {mix[B-1:0], mix[H-1:B]};
  assign r_new        = enc_q ? (l_wrot ^ f_dat) : mix_wrot_inv;

  // key round, same cycle
  logic [B-1:0] c_b;
  logic [H-1:0] cvec, f_key, f_key_wrot, kr_new;
  assign c_b  = B'(rconst);
  assign cvec = {{(H-B){1'b0}}, c_b};

  sfc_round_fn #(.NB(NB), .B(B)) u_key (
    .x_i (kr_q),
    .k_i (cvec),
    .y_o (f_key)
  );

  assign f_key_wrot = {f_key[H-B-1:0], f_key[H-1:H-B]};
  assign kr_new     = kl_q ^ f_key_wrot;

  assign st_en  = load || busy;
  assign res_en = busy && last;

  always_comb begin
    if (load) begin
      l_d   = block_i[N-1:H];
      r_d   = block_i[H-1:0];
      kl_d  = key_i[N-1:H];
      kr_d  = key_i[H-1:0];
      enc_d = encrypt_i;
    end else begin
      l_d   = r_q;
      r_d   = r_new;
      enc_d = enc_q;
      if (swap) begin
        kl_d = kr_new;
        kr_d = kr_q;
      end else begin
        kl_d = kr_q;
        kr_d = kr_new;
      end
    end
    res_d = {r_new, r_q};
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      l_q   <= '0;
      r_q   <= '0;
      kl_q  <= '0;
      kr_q  <= '0;
      enc_q <= 1'b0;
      res_q <= '0;
    end else begin
      if (st_en) begin
        l_q   <= l_d;
        r_q   <= r_d;
        kl_q  <= kl_d;
        kr_q  <= kr_d;
        enc_q <= enc_d;
      end
      if (res_en) begin
        res_q <= res_d;
      end
    end
  end

  assign result_o = res_q;

endmodule

// File: rtl/sfc_core_chk.sv
module sfc_core_chk #(
  parameter int unsigned N  = 96,
  parameter int unsigned NR = 93,
  localparam int unsigned RW = $clog2(NR + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [RW-1:0] rnd,
  input logic [N-1:0]  result
);
  logic [RW:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= '0;
    end else if (start && !busy) begin
      lat <= '0;
    end else if (busy) begin
      lat <= lat + 1'b1;
    end
  end

  // R1: completion after exactly NR round edges
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == (RW+1)'(NR)));

  // R1: completion only directly after a running cycle
  a_r1_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R2: single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: a start during a run does not restart the round count
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && rnd != RW'(NR)) |=> (rnd == $past(rnd) + RW'(1)));

  // R6: result stable except when completion is flagged
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

bind sfc_core sfc_core_chk #(.N(N), .NR(NR)) chk_i (
  .clk    (clk_i),
  .rst_n  (rst_sync_n),
  .start  (start_i),
  .busy   (busy),
  .done   (done_o),
  .rnd    (rnd),
  .result (result_o)
);

// File: tb/sfc_core_tb_top.sv
module sfc_core_tb_top;
  localparam int unsigned N    = 96;
  localparam int unsigned B    = 8;
  localparam int unsigned NR   = 93;
  localparam int unsigned H    = N / 2;
  localparam int unsigned NB   = H / B;
  localparam int unsigned HALF = NR / 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, enc;
  logic [N-1:0] blk, key;
  logic         done;
  logic [N-1:0] result;

  always #4 clk = ~clk;  // 125 MHz

  sfc_core #(.N(N), .B(B), .NR(NR)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .encrypt_i (enc),
    .block_i   (blk),
    .key_i     (key),
    .done_o    (done),
    .result_o  (result)
  );

  typedef struct {
    logic [N-1:0] exp;
    longint       due;
    string        tag;
  } item_t;

  item_t  sb_q[$];
  longint cyc = 0;
  int     total = 0, bad = 0;
  int     pushes = 0, done_seen = 0, pulse_bad = 0, hold_bad = 0;
  logic   mon_en = 1'b0, fin = 1'b0;
  logic         prev_done = 1'b0;
  logic [N-1:0] prev_res = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [H-1:0] m_wrot(input logic [H-1:0] x);
    logic [H-1:0] y;
    for (int i = 0; i < NB; i++) y[((i+1)%NB)*B +: B] = x[i*B +: B];
    return y;
  endfunction

  function automatic logic [H-1:0] m_wrot_inv(input logic [H-1:0] x);
    logic [H-1:0] y;
    for (int i = 0; i < NB; i++) y[i*B +: B] = x[((i+1)%NB)*B +: B];
    return y;
  endfunction

  function automatic logic [H-1:0] m_f(input logic [H-1:0] x, input logic [H-1:0] k);
    logic [2:0]   tbl [8];
    logic [H-1:0] s, q, y;
    logic [2:0]   v;
    logic [B-1:0] a, c;
    tbl = '{3'd0, 3'd5, 3'd6, 3'd7, 3'd4, 3'd3, 3'd1, 3'd2};
    for (int i = 0; i < NB; i++) s[i*B +: B] = x[i*B +: B] + k[i*B +: B];
    for (int t = 0; t < NB/3; t++) begin
      for (int j = 0; j < B; j++) begin
        v = tbl[{s[(3*t+2)*B+j], s[(3*t+1)*B+j], s[(3*t)*B+j]}];
        q[(3*t)*B+j]   = v[0];
        q[(3*t+1)*B+j] = v[1];
        q[(3*t+2)*B+j] = v[2];
      end
    end
    for (int t = 0; t < NB/3; t++) begin
      a = q[(3*t)*B +: B];
      c = q[(3*t+2)*B +: B];
      y[(3*t)*B +: B]   = (a >> 1) | (a << (B-1));
      y[(3*t+1)*B +: B] = q[(3*t+1)*B +: B];
      y[(3*t+2)*B +: B] = (c << 1) | (c >> (B-1));
    end
    return y;
  endfunction

  function automatic logic [N-1:0] model(input logic [N-1:0] p, input logic [N-1:0] k,
                                         input logic e);
    logic [H-1:0] l, r, kl, kr, rk, f, t, g, cv;
    int cst;
    l = p[N-1:H]; r = p[H-1:0]; kl = k[N-1:H]; kr = k[H-1:0];
    for (int i = 1; i <= NR; i++) begin
      rk = (i <= HALF) ? kr : kl;
      f  = m_f(r, rk);
      t  = e ? (m_wrot(l) ^ f) : m_wrot_inv(l ^ f);
      l  = r;
      r  = t;
      cst = (i <= HALF) ? i : NR - i;
      cv = '0;
      cv[B-1:0] = cst[B-1:0];
      g = kl ^ m_wrot(m_f(kr, cv));
      if (i == HALF) kl = g;
      else begin
        kl = kr;
        kr = g;
      end
    end
    return {r, l};
  endfunction

  function automatic logic [N-1:0] rvec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = 1'($urandom % 2);
    return v;
  endfunction

  // ---------------- driver ----------------
  task automatic launch(input logic [N-1:0] p, input logic [N-1:0] k, input logic e,
                        input string tag);
    item_t it;
    @(negedge clk);
    blk = p; key = k; enc = e; start = 1'b1;
    it.exp = model(p, k, e);
    it.due = cyc + 1 + NR;
    it.tag = tag;
    sb_q.push_back(it);
    pushes++;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic run(input logic [N-1:0] p, input logic [N-1:0] k, input logic e,
                     input string tag);
    launch(p, k, e, tag);
    drain();
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    item_t it;
    if (mon_en) begin
      if (done) begin
        done_seen++;
        if (prev_done) pulse_bad++;
        if (sb_q.size() == 0) begin
          check(1'b0, "R5 unexpected done", result, '0);
        end else begin
          it = sb_q.pop_front();
          check(result == it.exp, it.tag, result, it.exp);
          check(cyc == it.due, "R1 latency", N'(cyc), N'(it.due));
        end
      end else if (result != prev_res) begin
        hold_bad++;
      end
      prev_done = done;
      prev_res  = result;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [N-1:0] p, k, c;
    start = 1'b0; enc = 1'b0; blk = '0; key = '0; rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R7 reset state
    check(done == 1'b0, "R7 done after reset", N'(done), '0);
    check(result == '0, "R7 result after reset", result, '0);

    // R3 encryption patterns
    run('0, '0, 1'b1, "R3 zero block and key");
    run('1, '1, 1'b1, "R3 all-ones block and key");
    run({H{2'b01}}, {N{1'b0}} | 96'h1, 1'b1, "R3 sparse pattern");
    run(rvec(), rvec(), 1'b1, "R3 random");

    // R9 every word overflows in the addition
    p = {{H{1'b0}}, {NB{ {B{1'b1}} }}};
    k = {{H{1'b1}}, {NB{ {(B-1){1'b0}}, 1'b1 }}};
    run(p, k, 1'b1, "R9 carry isolation");

    // R8 direct decryption
    run(rvec(), rvec(), 1'b0, "R8 decrypt round");
    run('1, '0, 1'b0, "R8 decrypt ones");

    // R4 round trips
    for (int i = 0; i < 4; i++) begin
      p = rvec();
      k = rvec();
      c = model(p, k, 1'b1);
      run(p, k, 1'b1, "R4 encrypt leg");
      run(c, k, 1'b0, "R4 decrypt leg");
      check(model(c, k, 1'b0) == p, "R4 model round trip", model(c, k, 1'b0), p);
    end

    // R5 start while busy is ignored
    launch(rvec(), rvec(), 1'b1, "R5 run kept");
    repeat (10) @(negedge clk);
    blk = rvec(); key = rvec(); enc = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (NR + 5) @(negedge clk);
    check(done_seen == pushes, "R5 done count", N'(done_seen), N'(pushes));

    // R2 and R6 totals
    check(pulse_bad == 0, "R2 done longer than one cycle", N'(pulse_bad), '0);
    check(hold_bad == 0, "R6 result moved without done", N'(hold_bad), '0);

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule